// File: doc/BRIEF.md
# Isochronous IN Transmit Endpoint with Ping-Pong Packet Buffers

This block is the transmit side of one isochronous IN endpoint in a full-speed device controller. Firmware loads packet bytes through a byte-wide write port into one of two packet buffers. A buffer is committed either when it reaches the maximum packet size or when firmware requests a short commit through the control/status register. Committed packets wait in a two-deep ping-pong queue and are sent in the order in which they were committed.

The serial interface engine raises a token pulse for each IN token. One cycle later the endpoint answers with a data, NAK or zero-length response. For data it then streams the bytes under a valid/ready handshake. The engine pulses a packet-sent strobe once the host has received the packet. A sticky completion bit, cleared by writing 1, records each delivered packet, and an interrupt request follows it when interrupts are enabled. Both buffers can be flushed by a register write or by a pulse that marks a host configuration request.

Top module: `iso_in_ep`

## Requirements
- R1: After reset the service bit reads 1, the completion bit and interrupt-enable bit read 0, `irq` is 0, and `resp_valid` and `tx_valid` are 0.
- R2: The service bit (csr bit 0) reads 1 while zero or one committed packets are queued. It reads 0 while two are queued.
- R3: Writing MAX_PKT bytes into the fill buffer commits it as a full packet with no further action.
- R4: Writing 1 to csr bit 3 commits the partly filled buffer with the number of bytes written so far. Bit 3 always reads back 0.
- R5: An IN token while a packet is queued gives `resp_valid` with code 2'b01 and the packet length on `resp_len` in the next cycle. The bytes then stream in write order, oldest packet first, and `tx_last` marks the final byte.
- R6: A `pkt_sent` pulse after a data packet sets the completion bit (csr bit 1) and frees that buffer. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly while the completion bit and the interrupt-enable bit (csr bit 4, read/write) are both 1.
- R8: A set completion bit does not stop the next queued packet from being sent.
- R9: An IN token with no queued packet while the completion bit is 1 is answered with code 2'b10 (NAK).
- R10: An IN token with no queued packet while the completion bit is 0 is answered with code 2'b11 and length 0. Delivering that empty packet does not set the completion bit.
- R11: Writing 1 to csr bit 2, or pulsing `host_cfg_req`, empties both buffers and restarts filling at byte 0. Bit 2 always reads back 0.
- R12: Byte writes while two packets are queued are dropped and do not reach any later packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_wr | input | 1 | Byte write strobe from firmware |
| fifo_wdata | input | DW | Byte to append to the fill buffer |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value: bit0 service, bit1 complete, bit2 flush, bit3 short, bit4 irq enable |
| host_cfg_req | input | 1 | Pulse on a set-configuration or set-interface request |
| in_tok | input | 1 | IN token pulse from the interface engine |
| resp_valid | output | 1 | One-cycle token response strobe |
| resp_code | output | 2 | 01 data, 10 NAK, 11 zero-length |
| resp_len | output | clog2(MAX_PKT+1) | Byte count of the response packet |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | DW | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Engine accepts the current byte |
| pkt_sent | input | 1 | Engine reports the packet delivered |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench fills a full packet and then a short one, so the queue reaches two entries. A design that counted partial buffers as queued, or that kept the service bit high at two packets, would report the wrong service level. It drains both packets while the completion bit stays set. A design that blocked on that bit would NAK the second packet, and one that mixed up the ping-pong pointers would stream the bytes out of order. It then probes tokens on an empty queue with the completion bit set and with it clear, to separate NAK from zero-length, and checks that the zero-length delivery leaves the bit clear. It writes bytes while both buffers are full, and it flushes through the register and through the host request. After each flush it refills, which catches dropped bytes that leak into a packet and fill indexes that are not reset.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;

   // control/status register bit positions
   localparam int CSR_SVC   = 0;
   localparam int CSR_DONE  = 1;
   localparam int CSR_FLUSH = 2;
   localparam int CSR_SHORT = 3;
   localparam int CSR_IEN   = 4;

   typedef enum logic [1:0] {
      RSP_NONE = 2'b00,
      RSP_DATA = 2'b01,
      RSP_NAK  = 2'b10,
      RSP_ZLP  = 2'b11
   } rsp_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STREAM = 2'd1,
      ST_WAIT   = 2'd2
   } tx_st_e;

endpackage

// File: rtl/iso_in_buf.sv
module iso_in_buf #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/iso_in_queue.sv
module iso_in_queue #(
   parameter int MAX_PKT = 256,
   parameter int AW      = 8,
   parameter int LW      = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          byte_wr,
   input  logic          short_go,
   input  logic          pop,
   output logic [1:0]    level,
   output logic          wr_sel,
   output logic          rd_sel,
   output logic [AW-1:0] fill_idx,
   output logic [LW-1:0] head_len,
   output logic          wr_ok
);

   localparam logic [AW-1:0] LAST_IDX = AW'(MAX_PKT - 1);
   localparam logic [LW-1:0] FULL_LEN = LW'(MAX_PKT);

   logic [LW-1:0] len_q [2];
   logic          full_hit;
   logic          short_hit;
   logic          commit;
   logic          room;
   logic [LW-1:0] commit_len;

   always_comb begin
      room       = (level != 2'd2);
      wr_ok      = byte_wr && room && !flush;
      full_hit   = wr_ok && (fill_idx == LAST_IDX);
      short_hit  = short_go && room && !flush && !full_hit;
      commit     = full_hit || short_hit;
      commit_len = full_hit ? FULL_LEN : (LW'(fill_idx) + LW'(wr_ok));
      head_len   = len_q[rd_sel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         level    <= 2'd0;
         wr_sel   <= 1'b0;
         rd_sel   <= 1'b0;
         fill_idx <= '0;
      end else begin
         level <= level + {1'b0, commit} - {1'b0, pop};
         if (commit) begin
            wr_sel   <= ~wr_sel;
            fill_idx <= '0;
         end else if (wr_ok) begin
            fill_idx <= fill_idx + AW'(1);
         end
         if (pop) rd_sel <= ~rd_sel;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_len
      always_ff @(posedge clk) begin
         if (!rst_n)
            len_q[b] <= '0;
         else if (commit && (wr_sel == 1'(b)))
            len_q[b] <= commit_len;
      end
   end

endmodule

// File: rtl/iso_in_tx.sv
module iso_in_tx
   import iso_in_pkg::*;
#(
   parameter int AW = 8,
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          in_tok,
   input  logic          tx_ready,
   input  logic          pkt_sent,
   input  logic          have_pkt,
   input  logic          done,
   input  logic [LW-1:0] head_len,
   output logic          resp_valid,
   output logic [1:0]    resp_code,
   output logic [LW-1:0] resp_len,
   output logic          tx_valid,
   output logic          tx_last,
   output logic [AW-1:0] rd_idx,
   output logic          pop
);

   tx_st_e        st;
   logic [LW-1:0] cur_len;
   logic          real_q;

   always_comb begin
      tx_valid = (st == ST_STREAM);
      tx_last  = tx_valid && ((LW'(rd_idx) + LW'(1)) == cur_len);
      pop      = (st == ST_WAIT) && pkt_sent && real_q && !flush;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cur_len    <= '0;
         real_q     <= 1'b0;
         rd_idx     <= '0;
         resp_valid <= 1'b0;
         resp_code  <= RSP_NONE;
         resp_len   <= '0;
      end else begin
         resp_valid <= 1'b0;
         resp_code  <= RSP_NONE;
         resp_len   <= '0;
         if (flush) begin
            st     <= ST_IDLE;
            rd_idx <= '0;
         end else begin
            unique case (st)
               ST_IDLE: if (in_tok) begin
                  resp_valid <= 1'b1;
                  rd_idx     <= '0;
                  if (have_pkt) begin
                     resp_code <= RSP_DATA;
                     resp_len  <= head_len;
                     cur_len   <= head_len;
                     real_q    <= 1'b1;
                     st        <= (head_len == '0) ? ST_WAIT : ST_STREAM;
                  end else if (done) begin
                     resp_code <= RSP_NAK;
                  end else begin
                     resp_code <= RSP_ZLP;
                     real_q    <= 1'b0;
                     st        <= ST_WAIT;
                  end
               end
               ST_STREAM: if (tx_ready) begin
                  if (tx_last) st <= ST_WAIT;
                  else         rd_idx <= rd_idx + AW'(1);
               end
               ST_WAIT: if (pkt_sent) st <= ST_IDLE;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/iso_in_ep.sv
module iso_in_ep
   import iso_in_pkg::*;
#(
   parameter int MAX_PKT = 256,
   parameter int DW      = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_wr,
   input  logic [DW-1:0]                fifo_wdata,
   input  logic                         csr_wr,
   input  logic [7:0]                   csr_wdata,
   output logic [7:0]                   csr_rdata,
   input  logic                         host_cfg_req,
   input  logic                         in_tok,
   output logic                         resp_valid,
   output logic [1:0]                   resp_code,
   output logic [$clog2(MAX_PKT+1)-1:0] resp_len,
   output logic                         tx_valid,
   output logic [DW-1:0]                tx_data,
   output logic                         tx_last,
   input  logic                         tx_ready,
   input  logic                         pkt_sent,
   output logic                         irq
);

   localparam int AW = $clog2(MAX_PKT);
   localparam int LW = $clog2(MAX_PKT + 1);

   if (MAX_PKT < 2 || MAX_PKT > 1023) begin : g_bad_size
      $error("iso_in_ep: MAX_PKT must lie in 2..1023");
   end
   if (DW < 1) begin : g_bad_width
      $error("iso_in_ep: DW must be at least 1");
   end

   logic          flush;
   logic          short_go;
   logic          done_q;
   logic          ien_q;
   logic [1:0]    level;
   logic          wr_sel;
   logic          rd_sel;
   logic          wr_ok;
   logic          pop;
   logic [AW-1:0] fill_idx;
   logic [AW-1:0] rd_idx;
   logic [LW-1:0] head_len;
   logic [DW-1:0] buf_rdata [2];

   assign flush    = (csr_wr && csr_wdata[CSR_FLUSH]) || host_cfg_req;
   assign short_go = csr_wr && csr_wdata[CSR_SHORT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (pop)                               done_q <= 1'b1;
         else if (csr_wr && csr_wdata[CSR_DONE]) done_q <= 1'b0;
         if (csr_wr) ien_q <= csr_wdata[CSR_IEN];
      end
   end

   always_comb begin
      csr_rdata            = '0;
      csr_rdata[CSR_SVC]   = (level != 2'd2);
      csr_rdata[CSR_DONE]  = done_q;
      csr_rdata[CSR_IEN]   = ien_q;
      irq                  = done_q && ien_q;
   end

   iso_in_queue #(.MAX_PKT(MAX_PKT), .AW(AW), .LW(LW)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .byte_wr  (fifo_wr),
      .short_go (short_go),
      .pop      (pop),
      .level    (level),
      .wr_sel   (wr_sel),
      .rd_sel   (rd_sel),
      .fill_idx (fill_idx),
      .head_len (head_len),
      .wr_ok    (wr_ok)
   );

   for (genvar b = 0; b < 2; b++) begin : g_buf
      iso_in_buf #(.DEPTH(MAX_PKT), .DW(DW), .AW(AW)) u_buf (
         .clk   (clk),
         .we    (wr_ok && (wr_sel == 1'(b))),
         .waddr (fill_idx),
         .wdata (fifo_wdata),
         .raddr (rd_idx),
         .rdata (buf_rdata[b])
      );
   end

   assign tx_data = buf_rdata[rd_sel];

   iso_in_tx #(.AW(AW), .LW(LW)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .in_tok     (in_tok),
      .tx_ready   (tx_ready),
      .pkt_sent   (pkt_sent),
      .have_pkt   (level != 2'd0),
      .done       (done_q),
      .head_len   (head_len),
      .resp_valid (resp_valid),
      .resp_code  (resp_code),
      .resp_len   (resp_len),
      .tx_valid   (tx_valid),
      .tx_last    (tx_last),
      .rd_idx     (rd_idx),
      .pop        (pop)
   );

endmodule

// File: rtl/iso_in_chk.sv
module iso_in_chk #(
   parameter int MAX_PKT = 256
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         csr_wr,
   input logic [7:0]                   csr_wdata,
   input logic [7:0]                   csr_rdata,
   input logic                         host_cfg_req,
   input logic                         resp_valid,
   input logic [1:0]                   resp_code,
   input logic [$clog2(MAX_PKT+1)-1:0] resp_len,
   input logic                         tx_valid,
   input logic                         tx_ready,
   input logic                         tx_last,
   input logic                         irq
);

   // R9
   nak_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 2'b10) |-> $past(csr_rdata[1]));

   // R10
   zlp_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 2'b11) |-> (resp_len == '0) && !$past(csr_rdata[1]));

   // R5
   last_ends_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !tx_valid);

   // R6
   done_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(csr_rdata[1]) |-> $past(csr_wr && csr_wdata[1]));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (csr_rdata[1] && csr_rdata[4]));

   // R11
   cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_cfg_req |=> (csr_rdata[0] && !tx_valid));

endmodule

bind iso_in_ep iso_in_chk #(.MAX_PKT(MAX_PKT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_wr       (csr_wr),
   .csr_wdata    (csr_wdata),
   .csr_rdata    (csr_rdata),
   .host_cfg_req (host_cfg_req),
   .resp_valid   (resp_valid),
   .resp_code    (resp_code),
   .resp_len     (resp_len),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .tx_last      (tx_last),
   .irq          (irq)
);

// File: tb/sim_iso_in_ep.sv
`timescale 1ns/100ps
module sim_iso_in_ep;

   localparam int PKT = 8;
   localparam int LWB = $clog2(PKT + 1);

   // step op codes
   localparam logic [2:0] OP_WR = 3'd0;  // write n counted bytes
   localparam logic [2:0] OP_WX = 3'd1;  // write n filler bytes (expected dropped)
   localparam logic [2:0] OP_SH = 3'd2;  // short commit
   localparam logic [2:0] OP_TK = 3'd3;  // token, stream, deliver
   localparam logic [2:0] OP_CL = 3'd4;  // clear completion bit

   // {op, n, exp_code, exp_len, exp_svc, exp_done}
   localparam int NSTEP = 14;
   localparam logic [22:0] STEPS [NSTEP] = '{
      {OP_WR, 8'd8, 2'b00, 8'd0, 1'b1, 1'b0},  // R3 one full packet
      {OP_WR, 8'd3, 2'b00, 8'd0, 1'b1, 1'b0},  // partial stays uncounted
      {OP_SH, 8'd0, 2'b00, 8'd0, 1'b0, 1'b0},  // R4 R2 two queued
      {OP_TK, 8'd0, 2'b01, 8'd8, 1'b1, 1'b1},  // R5 R6 oldest first
      {OP_TK, 8'd0, 2'b01, 8'd3, 1'b1, 1'b1},  // R8 sent while done set
      {OP_TK, 8'd0, 2'b10, 8'd0, 1'b1, 1'b1},  // R9 nak
      {OP_CL, 8'd0, 2'b00, 8'd0, 1'b1, 1'b0},  // R6 w1c
      {OP_TK, 8'd0, 2'b11, 8'd0, 1'b1, 1'b0},  // R10 empty packet
      {OP_WR, 8'd8, 2'b00, 8'd0, 1'b1, 1'b0},
      {OP_WR, 8'd8, 2'b00, 8'd0, 1'b0, 1'b0},  // R2 full queue
      {OP_WX, 8'd2, 2'b00, 8'd0, 1'b0, 1'b0},  // R12 dropped
      {OP_TK, 8'd0, 2'b01, 8'd8, 1'b1, 1'b1},
      {OP_TK, 8'd0, 2'b01, 8'd8, 1'b1, 1'b1},  // R12 no leak
      {OP_TK, 8'd0, 2'b10, 8'd0, 1'b1, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fifo_wr = 1'b0;
   logic [7:0]       fifo_wdata = '0;
   logic             csr_wr = 1'b0;
   logic [7:0]       csr_wdata = '0;
   logic [7:0]       csr_rdata;
   logic             host_cfg_req = 1'b0;
   logic             in_tok = 1'b0;
   logic             resp_valid;
   logic [1:0]       resp_code;
   logic [LWB-1:0]   resp_len;
   logic             tx_valid;
   logic [7:0]       tx_data;
   logic             tx_last;
   logic             tx_ready = 1'b0;
   logic             pkt_sent = 1'b0;
   logic             irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] wr_val = 8'h10;
   logic [7:0] rd_val = 8'h10;

   always #2.5 clk = ~clk;

   iso_in_ep #(.MAX_PKT(PKT), .DW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .host_cfg_req(host_cfg_req), .in_tok(in_tok), .resp_valid(resp_valid),
      .resp_code(resp_code), .resp_len(resp_len), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .pkt_sent(pkt_sent), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_bytes(input int n, input bit counted);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fifo_wr    = 1'b1;
         fifo_wdata = counted ? wr_val : 8'hEE;
         if (counted) wr_val = wr_val + 8'd1;
      end
      @(negedge clk);
      fifo_wr = 1'b0;
   endtask

   task automatic csr_write(input logic [7:0] d);
      @(negedge clk);
      csr_wr    = 1'b1;
      csr_wdata = d;
      @(negedge clk);
      csr_wr    = 1'b0;
   endtask

   task automatic token(input int code, input int len, input string req);
      int cnt;
      @(negedge clk);
      in_tok = 1'b1;
      @(negedge clk);
      in_tok = 1'b0;
      chk(resp_valid == 1'b1, req, int'(resp_valid), 1);
      chk(int'(resp_code) == code, req, int'(resp_code), code);
      chk(int'(resp_len) == len, req, int'(resp_len), len);
      cnt = 0;
      if (code == 1) begin
         tx_ready = 1'b1;
         while (tx_valid && cnt < 64) begin
            chk(tx_data == rd_val, req, int'(tx_data), int'(rd_val));
            chk(tx_last == (cnt == len - 1), req, int'(tx_last), int'(cnt == len - 1));
            rd_val = rd_val + 8'd1;
            cnt++;
            @(negedge clk);
         end
         tx_ready = 1'b0;
         chk(cnt == len, req, cnt, len);
      end
      if (code != 2) begin
         pkt_sent = 1'b1;
         @(negedge clk);
         pkt_sent = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(csr_rdata[0] == 1'b1, "R1", int'(csr_rdata[0]), 1);
      chk(csr_rdata[1] == 1'b0, "R1", int'(csr_rdata[1]), 0);
      chk(csr_rdata[4] == 1'b0, "R1", int'(csr_rdata[4]), 0);
      chk(irq == 1'b0, "R1", int'(irq), 0);
      chk(!resp_valid && !tx_valid, "R1", int'(resp_valid || tx_valid), 0);

      for (int s = 0; s < NSTEP; s++) begin
         logic [2:0] op;
         op = STEPS[s][22:20];
         case (op)
            OP_WR: wr_bytes(int'(STEPS[s][19:12]), 1'b1);
            OP_WX: wr_bytes(int'(STEPS[s][19:12]), 1'b0);
            OP_SH: csr_write(8'h08);
            OP_TK: token(int'(STEPS[s][11:10]), int'(STEPS[s][9:2]), "R5/R8/R9/R10 token");
            default: csr_write(8'h02);
         endcase
         chk(csr_rdata[0] == STEPS[s][1], "R2 service", int'(csr_rdata[0]), int'(STEPS[s][1]));
         chk(csr_rdata[1] == STEPS[s][0], "R6 done", int'(csr_rdata[1]), int'(STEPS[s][0]));
      end

      // R7 enable low masks request while done set
      chk(irq == 1'b0, "R7", int'(irq), 0);
      // R6 writing zero leaves completion bit
      csr_write(8'h00);
      chk(csr_rdata[1] == 1'b1, "R6", int'(csr_rdata[1]), 1);
      // R7 enable raises request
      csr_write(8'h10);
      chk(irq == 1'b1, "R7", int'(irq), 1);
      // R7 clearing done drops request
      csr_write(8'h12);
      chk(irq == 1'b0, "R7", int'(irq), 0);
      chk(csr_rdata[1] == 1'b0, "R6", int'(csr_rdata[1]), 0);

      // R4 short bit reads back zero
      wr_bytes(2, 1'b1);
      csr_write(8'h18);
      chk(csr_rdata[3] == 1'b0, "R4", int'(csr_rdata[3]), 0);
      // R11 register flush, flush bit reads zero, queue empty
      csr_write(8'h14);
      chk(csr_rdata[2] == 1'b0, "R11", int'(csr_rdata[2]), 0);
      token(3, 0, "R11 after register flush");

      // R11 host configuration flush
      wr_bytes(2 * PKT, 1'b1);
      chk(csr_rdata[0] == 1'b0, "R11 pre", int'(csr_rdata[0]), 0);
      @(negedge clk);
      host_cfg_req = 1'b1;
      @(negedge clk);
      host_cfg_req = 1'b0;
      chk(csr_rdata[0] == 1'b1, "R11", int'(csr_rdata[0]), 1);
      token(3, 0, "R11 after host flush");

      // R11 R3 refill restarts at byte 0
      rd_val = wr_val;
      wr_bytes(PKT, 1'b1);
      token(1, PKT, "R3 refill");
      chk(irq == 1'b1, "R7", int'(irq), 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule